// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one I2C master transaction at the byte level. Software programs a byte count and writes a control word holding enable, master, direction, extended-address, stop and start bits. When a valid start is requested, the sequencer sends a start command that carries the 7-bit slave address and the read/write bit to a byte-level bus engine. If the slave acknowledges, the sequencer moves the programmed number of bytes through a small transmit or receive buffer. When the count is exhausted, it either ends the transfer with a stop or reports access-ready and leaves master mode.

The bus engine sees one command at a time on a valid/done handshake. The command codes are start=0, send=1, receive=2 and stop=3. A start carries `{slave_addr, rw}` in its data byte, a send carries a data byte, and each receive returns a byte on `bus_rdata`. Bit-level line timing, slave operation and 10-bit addressing are outside this block.

Top module: `i2c_mseq`

## Requirements
- R1: The control register stores the written word ANDed with 0xCF87. The bit positions are enable=15, master=10, transmit=9, extended address=8, stop=1 and start=0.
- R2: A control write with enable, master and start set, with extended address clear, while the sequencer is idle, issues one start command (code 0) with data `{slave_addr, ~transmit}`. The start bit reads 0 once that command completes. While a command waits for `bus_done`, its code and data stay stable.
- R3: A start completed with `bus_nack` sets status bit 1 (NACK), clears the start and stop bits, moves no data and returns to idle.
- R4: An acknowledged start loads the remaining-byte counter from the programmed count. In transmit mode it then issues exactly that many send commands (code 1), carrying the buffered bytes in write order.
- R5: In receive mode the block issues one receive command (code 2) per counted byte and stores each returned byte in the receive buffer in order. It issues no receive while the buffer (depth 4) is full. Each stored byte sets status bit 3 (RRDY).
- R6: When the counter reaches zero with stop set, the block issues a stop command (code 3). On its completion the stop bit clears, the counter reloads from the count and the transmit buffer level becomes 0.
- R7: When the counter reaches zero with stop clear, no stop is issued, status bit 2 (ARDY) is set and the master bit clears.
- R8: A control write with enable set and either master clear or extended address set issues no command, and the sequencer stays idle.
- R9: A read that empties the receive buffer clears RRDY. If the control word then shows master set and transmit clear, the same read sets ARDY.
- R10: A transmit that is waiting on an empty buffer issues no send and sets status bit 4 (XRDY). A transmit-buffer write clears XRDY.
- R11: A control write with enable clear drops any pending command, returns the sequencer to idle (busy low) and empties the transmit buffer.
- R12: A status clear write clears exactly the status bits set in its mask. Status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_addr | input | 7 | Target slave address |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | CNT_W | Byte count |
| tx_we | input | 1 | Transmit byte write (ignored when full) |
| tx_wdata | input | 8 | Transmit byte |
| rx_re | input | 1 | Receive byte read (ignored when empty) |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 5 | Status bits to clear |
| bus_done | input | 1 | Bus engine completed the pending command |
| bus_nack | input | 1 | Start was not acknowledged (valid with bus_done) |
| bus_rdata | input | 8 | Received byte (valid with bus_done) |
| ctrl_rdata | output | 16 | Control register |
| status | output | 5 | XRDY(4) RRDY(3) ARDY(2) NACK(1), bit 0 zero |
| xfer_left | output | CNT_W | Remaining-byte counter |
| tx_level | output | LVL_W | Transmit buffer fill |
| rx_level | output | LVL_W | Receive buffer fill |
| rx_rdata | output | 8 | Head of receive buffer |
| busy | output | 1 | Sequencer not idle |
| bus_cmd_valid | output | 1 | Command pending to bus engine |
| bus_cmd | output | 2 | Command code |
| bus_cmd_data | output | 8 | Address byte or data byte |

## Verification
The bench sweeps transfer lengths from 0 to the buffer depth in both directions, with and without stop. This catches an off-by-one in the counter, which would add or drop a send or receive. It also catches a stop that is issued or skipped in the wrong case. Zero-length transfers show whether ARDY and the counter reload are handled without data moving. A receive longer than the buffer and a transmit with no data show whether the full and empty stalls hold, since a broken stall would overrun the buffer or send stale bytes. A NACK on start, the rejected modes and a mid-transfer abort check that a stop is cancelled, that no command leaks out and that the sequencer truly returns to idle.

// File: rtl/i2c_mseq_pkg.sv
package i2c_mseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_XFER,
        S_WAIT,
        S_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_SEND  = 2'd1,
        BC_RECV  = 2'd2,
        BC_STOP  = 2'd3
    } bus_cmd_e;

    localparam logic [15:0] CTRL_MASK = 16'hCF87;
    localparam int B_EN   = 15;
    localparam int B_MST  = 10;
    localparam int B_TRX  = 9;
    localparam int B_XA   = 8;
    localparam int B_STP  = 1;
    localparam int B_STT  = 0;

    localparam int B_XRDY = 4;
    localparam int B_RRDY = 3;
    localparam int B_ARDY = 2;
    localparam int B_NACK = 1;
    localparam int STAT_W = 5;

endpackage

// File: rtl/i2c_mseq_fifo.sv
module i2c_mseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [LW-1:0] lvl_d, lvl_q;

    always_comb begin
        wr_d  = wr_q;
        rd_d  = rd_q;
        lvl_d = lvl_q;
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            lvl_d = '0;
        end else begin
            if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
            if (push && !pop) lvl_d = lvl_q + 1'b1;
            else if (pop && !push) lvl_d = lvl_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            lvl_q <= lvl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[wr_q] <= din;
    end

    assign dout  = mem_q[rd_q];
    assign empty = (lvl_q == '0);
    assign full  = (lvl_q == LW'(DEPTH));
    assign level = lvl_q;

    // R5: the buffer never accepts a byte while full
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    // R10: no byte is taken from an empty buffer
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/i2c_mseq_fsm.sv
module i2c_mseq_fsm
    import i2c_mseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        slave_addr,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              tx_we,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_mask,
    input  logic              tx_empty,
    input  logic [7:0]        tx_head,
    input  logic              rx_full,
    input  logic              rx_pop,
    input  logic              rx_last,
    input  logic              bus_done,
    input  logic              bus_nack,
    output logic              tx_pop,
    output logic              tx_flush,
    output logic              rx_push,
    output logic [15:0]       ctrl_rdata,
    output logic [STAT_W-1:0] status,
    output logic [CNT_W-1:0]  xfer_left,
    output logic              busy,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [7:0]        bus_cmd_data
);
    typedef struct packed {
        seq_state_e        st;
        logic [15:0]       ctrl;
        logic [STAT_W-1:0] stat;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  left;
        logic              cv;
        bus_cmd_e          cmd;
        logic [7:0]        cd;
    } seq_t;

    seq_t q, d;
    logic start_ok;

    assign start_ok = ctrl_wdata[B_MST] && !ctrl_wdata[B_XA] && ctrl_wdata[B_STT];

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        rx_push  = 1'b0;

        if (stat_clr_we) d.stat = q.stat & ~stat_clr_mask;
        if (tx_we) d.stat[B_XRDY] = 1'b0;
        if (rx_pop && rx_last) begin
            d.stat[B_RRDY] = 1'b0;
            if (q.ctrl[B_MST] && !q.ctrl[B_TRX]) d.stat[B_ARDY] = 1'b1;
        end
        if (cnt_we) d.cnt = cnt_wdata;

        unique case (q.st)
            S_START: if (bus_done) begin
                d.cv          = 1'b0;
                d.ctrl[B_STT] = 1'b0;
                if (bus_nack) begin
                    d.stat[B_NACK] = 1'b1;
                    d.ctrl[B_STP]  = 1'b0;
                    d.st           = S_IDLE;
                end else begin
                    d.left = q.cnt;
                    d.st   = S_XFER;
                end
            end
            S_XFER: begin
                if (q.left == '0) begin
                    if (q.ctrl[B_STP]) begin
                        d.cv  = 1'b1;
                        d.cmd = BC_STOP;
                        d.st  = S_STOP;
                    end else begin
                        d.stat[B_ARDY] = 1'b1;
                        d.ctrl[B_MST]  = 1'b0;
                        d.st           = S_IDLE;
                    end
                end else if (q.ctrl[B_TRX]) begin
                    if (!tx_empty) begin
                        d.cv   = 1'b1;
                        d.cmd  = BC_SEND;
                        d.cd   = tx_head;
                        tx_pop = 1'b1;
                        d.st   = S_WAIT;
                    end else if (!tx_we) begin
                        d.stat[B_XRDY] = 1'b1;
                    end
                end else if (!rx_full) begin
                    d.cv  = 1'b1;
                    d.cmd = BC_RECV;
                    d.st  = S_WAIT;
                end
            end
            S_WAIT: if (bus_done) begin
                d.cv   = 1'b0;
                d.left = q.left - 1'b1;
                if (q.cmd == BC_RECV) begin
                    rx_push        = 1'b1;
                    d.stat[B_RRDY] = 1'b1;
                end
                d.st = S_XFER;
            end
            S_STOP: if (bus_done) begin
                d.cv          = 1'b0;
                d.ctrl[B_STP] = 1'b0;
                d.left        = q.cnt;
                tx_flush      = 1'b1;
                d.st          = S_IDLE;
            end
            default: ;
        endcase

        if (ctrl_we) begin
            d.ctrl = ctrl_wdata & CTRL_MASK;
            if (!ctrl_wdata[B_EN]) begin
                d.st     = S_IDLE;
                d.cv     = 1'b0;
                tx_flush = 1'b1;
                tx_pop   = 1'b0;
                rx_push  = 1'b0;
            end else if (q.st == S_IDLE && start_ok) begin
                d.st  = S_START;
                d.cv  = 1'b1;
                d.cmd = BC_START;
                d.cd  = {slave_addr, ~ctrl_wdata[B_TRX]};
            end
        end
        d.stat[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.ctrl <= '0;
            q.stat <= '0;
            q.cnt  <= '0;
            q.left <= '0;
            q.cv   <= 1'b0;
            q.cmd  <= BC_START;
            q.cd   <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_rdata    = q.ctrl;
    assign status        = q.stat;
    assign xfer_left     = q.left;
    assign busy          = (q.st != S_IDLE);
    assign bus_cmd_valid = q.cv;
    assign bus_cmd       = q.cmd;
    assign bus_cmd_data  = q.cd;

    // R2: a pending command holds until the engine completes it
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cv && !bus_done && !(ctrl_we && !ctrl_wdata[B_EN]))
        |=> (q.cv && $stable(q.cmd) && $stable(q.cd)));
    // R2: start bit self-clears once the start completes
    p_stt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START && bus_done && !ctrl_we) |=> !q.ctrl[B_STT]);
    // R3: refused start records NACK, cancels stop, goes idle
    p_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START && bus_done && bus_nack && !ctrl_we)
        |=> (q.stat[B_NACK] && !q.ctrl[B_STP] && q.st == S_IDLE));
    // R6: stop completion clears stop and reloads the counter
    p_stop_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_STOP && bus_done && !ctrl_we)
        |=> (!q.ctrl[B_STP] && q.left == $past(q.cnt)));
    // R7: end of count without stop raises ARDY and leaves master mode
    p_ardy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_XFER && q.left == '0 && !q.ctrl[B_STP] && !ctrl_we)
        |=> (q.stat[B_ARDY] && !q.ctrl[B_MST]));
    // R8: slave mode or extended addressing never leaves idle
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && ctrl_we && (!ctrl_wdata[B_MST] || ctrl_wdata[B_XA]))
        |=> (q.st == S_IDLE && !q.cv));
    // R11: clearing enable aborts to idle with no command pending
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_wdata[B_EN]) |=> (q.st == S_IDLE && !q.cv));
    // R12: status bit 0 is never set
    p_stat0_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !q.stat[0]);

endmodule

// File: rtl/i2c_mseq.sv
module i2c_mseq
    import i2c_mseq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int BUF_DEPTH = 4,
    localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        slave_addr,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              tx_we,
    input  logic [7:0]        tx_wdata,
    input  logic              rx_re,
    input  logic              stat_clr_we,
    input  logic [4:0]        stat_clr_mask,
    input  logic              bus_done,
    input  logic              bus_nack,
    input  logic [7:0]        bus_rdata,
    output logic [15:0]       ctrl_rdata,
    output logic [4:0]        status,
    output logic [CNT_W-1:0]  xfer_left,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic [7:0]        rx_rdata,
    output logic              busy,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [7:0]        bus_cmd_data
);
    logic       tx_empty, tx_full, tx_pop, tx_flush, tx_push;
    logic [7:0] tx_head;
    logic       rx_empty, rx_full, rx_push, rx_pop;

    assign tx_push = tx_we && !tx_full;
    assign rx_pop  = rx_re && !rx_empty;

    i2c_mseq_fifo #(.W(8), .DEPTH(BUF_DEPTH)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (tx_wdata),
        .pop   (tx_pop),
        .flush (tx_flush),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full),
        .level (tx_level)
    );

    i2c_mseq_fifo #(.W(8), .DEPTH(BUF_DEPTH)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (bus_rdata),
        .pop   (rx_pop),
        .flush (1'b0),
        .dout  (rx_rdata),
        .empty (rx_empty),
        .full  (rx_full),
        .level (rx_level)
    );

    i2c_mseq_fsm #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .slave_addr    (slave_addr),
        .ctrl_we       (ctrl_we),
        .ctrl_wdata    (ctrl_wdata),
        .cnt_we        (cnt_we),
        .cnt_wdata     (cnt_wdata),
        .tx_we         (tx_we),
        .stat_clr_we   (stat_clr_we),
        .stat_clr_mask (stat_clr_mask),
        .tx_empty      (tx_empty),
        .tx_head       (tx_head),
        .rx_full       (rx_full),
        .rx_pop        (rx_pop),
        .rx_last       (rx_level == LVL_W'(1)),
        .bus_done      (bus_done),
        .bus_nack      (bus_nack),
        .tx_pop        (tx_pop),
        .tx_flush      (tx_flush),
        .rx_push       (rx_push),
        .ctrl_rdata    (ctrl_rdata),
        .status        (status),
        .xfer_left     (xfer_left),
        .busy          (busy),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd       (bus_cmd),
        .bus_cmd_data  (bus_cmd_data)
    );

endmodule

// File: tb/i2c_mseq_test.sv
module i2c_mseq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam logic [6:0] SA = 7'h5A;
    localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                            XA = 16'h0100, STP = 16'h0002, STT = 16'h0001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctrl_we = 0, cnt_we = 0, tx_we = 0, rx_re = 0, stat_clr_we = 0;
    logic [15:0] ctrl_wdata = '0;
    logic [7:0]  cnt_wdata = '0, tx_wdata = '0;
    logic [4:0]  stat_clr_mask = '0;
    logic        bus_done = 0, bus_nack = 0;
    logic [7:0]  bus_rdata = '0;
    logic [15:0] ctrl_rdata;
    logic [4:0]  status;
    logic [7:0]  xfer_left, rx_rdata, bus_cmd_data;
    logic [2:0]  tx_level, rx_level;
    logic        busy, bus_cmd_valid;
    logic [1:0]  bus_cmd;

    int total = 0, bad = 0, cyc = 0;
    int wcnt = 0, nlog = 0, rxn = 0;
    logic nack_next = 0;
    logic [1:0] lcmd [16];
    logic [7:0] ldat [16];

    i2c_mseq uut (.*, .slave_addr(SA));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // bus engine model
    always @(negedge clk) begin
        if (bus_done) begin
            bus_done = 0; bus_nack = 0;
        end else if (bus_cmd_valid) begin
            if (wcnt == LAT) begin
                wcnt = 0;
                bus_done = 1;
                if (nlog < 16) begin lcmd[nlog] = bus_cmd; ldat[nlog] = bus_cmd_data; end
                nlog++;
                if (bus_cmd == 2'd0) begin bus_nack = nack_next; nack_next = 0; end
                if (bus_cmd == 2'd2) begin bus_rdata = 8'hC0 + 8'(rxn); rxn++; end
            end else wcnt++;
        end else wcnt = 0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_wdata = v; ctrl_we = 1; @(negedge clk); ctrl_we = 0;
    endtask
    task automatic wr_cnt(input int n);
        cnt_wdata = 8'(n); cnt_we = 1; @(negedge clk); cnt_we = 0;
    endtask
    task automatic push(input logic [7:0] b);
        tx_wdata = b; tx_we = 1; @(negedge clk); tx_we = 0;
    endtask
    task automatic pop(output logic [7:0] b);
        b = rx_rdata; rx_re = 1; @(negedge clk); rx_re = 0;
    endtask
    task automatic clr(input logic [4:0] m);
        stat_clr_mask = m; stat_clr_we = 1; @(negedge clk); stat_clr_we = 0;
    endtask
    task automatic idle_wait(input string tag);
        int k = 0;
        while (busy && k < 400) begin @(negedge clk); k++; end
        chk(tag, busy, 0);
    endtask
    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] b;
        settle(3);
        rst_n = 1;
        settle(1);
        chk("reset ctrl R1", ctrl_rdata, 0);
        chk("reset status R12", status, 0);
        chk("reset busy R11", busy, 0);
        chk("reset cmd R2", bus_cmd_valid, 0);

        // R1 + R8: all bits written, extended address rejects the start
        wr_ctrl(16'hFFFF);
        settle(8);
        chk("mask R1", ctrl_rdata, 16'hCF87);
        chk("xa reject R8", nlog, 0);
        chk("xa idle R8", busy, 0);
        wr_ctrl(EN | STT);
        settle(8);
        chk("slave reject R8", nlog, 0);
        chk("slave idle R8", busy, 0);

        // R3: refused start cancels stop
        wr_cnt(2); push(8'h11); push(8'h22);
        nack_next = 1;
        wr_ctrl(EN | MST | TRX | STP | STT);
        idle_wait("nack idle R3");
        chk("nack bit R3", status[1], 1);
        chk("nack ctrl R3", ctrl_rdata[1:0], 0);
        chk("nack log R3", nlog, 1);
        chk("nack level R3", tx_level, 2);
        wr_ctrl(16'h0000);
        chk("abort flush R11", tx_level, 0);
        clr(5'h1F);
        chk("clear all R12", status, 0);

        // transmit sweep: R2 R4 R6 R7
        for (int n = 0; n <= 4; n++) begin
            for (int s = 0; s < 2; s++) begin
                nlog = 0;
                clr(5'h1F);
                wr_cnt(n);
                for (int i = 0; i < n; i++) push(8'(8'h30 + n*8 + i));
                wr_ctrl(EN | MST | TRX | (s ? STP : 16'h0) | STT);
                idle_wait("tx done R4");
                chk("tx log len R4", nlog, 1 + n + s);
                chk("tx start cmd R2", lcmd[0], 0);
                chk("tx addr R2", ldat[0], {SA, 1'b0});
                for (int i = 0; i < n; i++) begin
                    chk("tx send cmd R4", lcmd[1+i], 1);
                    chk("tx send data R4", ldat[1+i], 8'(8'h30 + n*8 + i));
                end
                if (s) chk("tx stop cmd R6", lcmd[1+n], 3);
                chk("tx stt clear R2", ctrl_rdata[0], 0);
                chk("tx stp clear R6", ctrl_rdata[1], 0);
                chk("tx level R6", tx_level, 0);
                chk("tx left R6/R7", xfer_left, s ? n : 0);
                chk("tx ardy R7", status[2], s ? 0 : 1);
                chk("tx mst R7", ctrl_rdata[10], s ? 1 : 0);
            end
        end

        // receive sweep: R2 R5 R6 R7 R9
        for (int n = 0; n <= 4; n++) begin
            for (int s = 0; s < 2; s++) begin
                nlog = 0; rxn = 0;
                clr(5'h1F);
                wr_cnt(n);
                wr_ctrl(EN | MST | (s ? STP : 16'h0) | STT);
                idle_wait("rx done R5");
                chk("rx log len R5", nlog, 1 + n + s);
                chk("rx addr R2", ldat[0], {SA, 1'b1});
                for (int i = 0; i < n; i++) chk("rx recv cmd R5", lcmd[1+i], 2);
                if (s) chk("rx stop cmd R6", lcmd[1+n], 3);
                chk("rx level R5", rx_level, n);
                chk("rx rrdy set R5", status[3], n > 0);
                for (int i = 0; i < n; i++) begin
                    pop(b);
                    chk("rx data R5", b, 8'(8'hC0 + i));
                end
                chk("rx rrdy clear R9", status[3], 0);
                chk("rx ardy R9", status[2], (n > 0 || s == 0) ? 1 : 0);
            end
        end

        // R5: receive stalls on a full buffer
        nlog = 0; rxn = 0;
        clr(5'h1F);
        wr_cnt(6);
        wr_ctrl(EN | MST | STP | STT);
        settle(60);
        chk("rx stall count R5", nlog, 5);
        chk("rx stall busy R5", busy, 1);
        pop(b);
        chk("rx stall data R5", b, 8'hC0);
        settle(30);
        chk("rx resume R5", nlog, 6);
        for (int i = 1; i < 6; i++) begin
            int k = 0;
            while (rx_level == 0 && k < 100) begin @(negedge clk); k++; end
            pop(b);
            chk("rx long data R5", b, 8'(8'hC0 + i));
        end
        idle_wait("rx long done R6");
        chk("rx long log R6", nlog, 8);

        // R10: transmit stalls on empty buffer
        nlog = 0;
        clr(5'h1F);
        wr_cnt(2);
        wr_ctrl(EN | MST | TRX | STP | STT);
        settle(20);
        chk("tx stall log R10", nlog, 1);
        chk("tx xrdy R10", status[4], 1);
        push(8'h9A);
        chk("tx xrdy clear R10", status[4], 0);
        push(8'h9B);
        idle_wait("tx stall done R10");
        chk("tx stall len R10", nlog, 4);
        chk("tx stall d0 R10", ldat[1], 8'h9A);
        chk("tx stall d1 R10", ldat[2], 8'h9B);

        // R12: selective clear (ARDY from a no-stop run)
        clr(5'h1F);
        nack_next = 1;
        wr_ctrl(EN | MST | TRX | STT);
        idle_wait("nack2 R3");
        wr_cnt(0);
        wr_ctrl(EN | MST | TRX | STT);
        idle_wait("zero R7");
        chk("both set R12", status & 5'h06, 5'h06);
        clr(5'h04);
        chk("sel clear R12", status & 5'h06, 5'h02);

        // R11: abort a stalled transfer
        nlog = 0;
        wr_cnt(3);
        wr_ctrl(EN | MST | TRX | STT);
        settle(15);
        chk("abort pre busy R11", busy, 1);
        wr_ctrl(16'h0000);
        chk("abort busy R11", busy, 0);
        chk("abort cmd R11", bus_cmd_valid, 0);
        settle(10);
        chk("abort quiet R11", nlog, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule